// File: doc/BRIEF.md
# ADC Start-Pulse Source Selector

This block issues the single-cycle start pulse that an analog-to-digital conversion controller needs before each conversion. The pulse can come from one of three sources. The first is a start bit that software sets and that clears itself. The second is a periodic tick taken from the main clock divided by 2^DIV_LOG2, which is 256 by default. The third is the rising edge of an asynchronous external trigger pin. Two mode bits choose the source.

`hw_trig_en` = 0 selects software start. `hw_trig_en` = 1 selects a hardware source, and `src_sel` then picks it: 0 for the periodic tick, 1 for the external pin. A flag from the clock-gear logic says whether the main clock runs at full speed. The periodic tick is honoured only while that flag is high. The block has no data path, so it has no valid/ready interface, and every pin is a plain control or status signal.

Top module: `adc_start_select`

## Requirements
- R1: With `hw_trig_en`=0, a write strobe carrying data 1 makes `sw_start_rd` read 1 for exactly the next cycle. `conv_start` then pulses in the cycle after that, and the bit reads 0 again. A write carrying data 0 has no effect.
- R2: A write that arrives while `sw_start_rd` reads 1 is ignored. A strobe held high therefore produces one pulse every second cycle.
- R3: With `hw_trig_en`=1, software writes are ignored. `sw_start_rd` stays 0 and no software pulse is issued.
- R4: In periodic mode (`hw_trig_en`=1, `src_sel`=0) with `gear_full`=1, the first pulse appears on the 257th rising clock edge after the new mode is applied. This counts the edge that first samples the new mode as the first edge. Later pulses follow every 256 cycles. The divider restarts on every mode change.
- R5: While `gear_full`=0, periodic mode produces no pulses.
- R6: In external mode (`hw_trig_en`=1, `src_sel`=1), a rising edge on `ext_trig_pin` yields exactly one pulse. The pulse is visible after the third clock edge following the pin change, because the pin passes through a two-flop synchroniser and an edge register.
- R7: In external mode, falling edges and steady levels on `ext_trig_pin` produce no pulse. This includes a pin that is already high when the mode is entered.
- R8: With `hw_trig_en`=0, the external pin and the periodic tick produce no pulse.
- R9: Every `conv_start` pulse is exactly one clock cycle wide.
- R10: During and right after reset, `conv_start` and `sw_start_rd` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_trig_en | input | 1 | 1 = hardware source, 0 = software start bit |
| src_sel | input | 1 | Hardware source: 0 = periodic tick, 1 = external pin |
| gear_full | input | 1 | Main clock gear at full speed |
| sw_start_wr | input | 1 | Write strobe for the start bit |
| sw_start_wdata | input | 1 | Value written to the start bit |
| ext_trig_pin | input | 1 | Asynchronous external trigger |
| conv_start | output | 1 | One-cycle conversion start pulse |
| sw_start_rd | output | 1 | Readback of the self-clearing start bit |

## Verification
A divider that is not restarted on a mode change shows at the ports as a first periodic pulse earlier or later than edge 257. The error is visible within one 256-cycle period. A stuck synchroniser or edge register shows within three or four cycles of a pin change, either as a missing pulse, a duplicated pulse or a pulse on a falling edge. A start bit that fails to clear shows in the very next cycle as a readback that stays high or as repeated pulses. Every expected pulse is pinned to an exact edge, so a one-cycle slip in any of these paths is caught.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  // {hardware enable, source select}
  typedef enum logic [1:0] {
    MODE_SOFT_A   = 2'b00,
    MODE_SOFT_B   = 2'b01,
    MODE_PERIODIC = 2'b10,
    MODE_EXTERN   = 2'b11
  } trig_mode_e;

  function automatic trig_mode_e decode_mode(input logic hw, input logic src);
    return trig_mode_e'({hw, src});
  endfunction
endpackage

// File: rtl/adc_trig_sw_start.sv
module adc_trig_sw_start (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_sel,
  input  logic wr_strobe,
  input  logic wr_bit,
  output logic pend_o,
  output logic fire_o
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= wr_strobe & wr_bit & ~hw_sel & ~pend_q;
  end

  assign pend_o = pend_q;
  assign fire_o = pend_q & ~hw_sel;
endmodule

// File: rtl/adc_trig_divider.sv
module adc_trig_divider #(
  parameter int DIV_LOG2 = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick_o
);
  logic [DIV_LOG2-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart || !run)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run & ~restart & (&cnt_q);
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise_o
);
  localparam int TOP = SYNC_STAGES - 1;
  logic [TOP:0] sync_q;
  logic         prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= pin;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[TOP];
  end

  assign rise_o = sync_q[TOP] & ~prev_q;
endmodule

// File: rtl/adc_start_select.sv
module adc_start_select
  import adc_trig_pkg::*;
#(
  parameter int DIV_LOG2    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_trig_en,
  input  logic src_sel,
  input  logic gear_full,
  input  logic sw_start_wr,
  input  logic sw_start_wdata,
  input  logic ext_trig_pin,
  output logic conv_start,
  output logic sw_start_rd
);
  trig_mode_e mode, mode_q;
  logic       mode_chg;
  logic       sw_fire, div_tick, ext_rise, start_d, start_q;

  assign mode     = decode_mode(hw_trig_en, src_sel);
  assign mode_chg = (mode != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_SOFT_A;
    else        mode_q <= mode;
  end

  adc_trig_sw_start u_sw (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_sel    (hw_trig_en),
    .wr_strobe (sw_start_wr),
    .wr_bit    (sw_start_wdata),
    .pend_o    (sw_start_rd),
    .fire_o    (sw_fire)
  );

  adc_trig_divider #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (mode == MODE_PERIODIC),
    .restart (mode_chg),
    .tick_o  (div_tick)
  );

  adc_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin    (ext_trig_pin),
    .rise_o (ext_rise)
  );

  always_comb begin
    unique case (mode)
      MODE_PERIODIC: start_d = div_tick & gear_full;
      MODE_EXTERN:   start_d = ext_rise;
      default:       start_d = sw_fire;
    endcase
    start_d = start_d & ~start_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_d;
  end

  assign conv_start = start_q;
endmodule

// File: rtl/adc_start_select_chk.sv
module adc_start_select_chk (
  input logic clk,
  input logic rst_n,
  input logic hw_trig_en,
  input logic src_sel,
  input logic gear_full,
  input logic ext_trig_pin,
  input logic conv_start,
  input logic sw_start_rd
);
  // R1
  soft_pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !$past(hw_trig_en)) |-> $past(sw_start_rd));

  // R3
  hw_blocks_soft_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_trig_en |=> !sw_start_rd);

  // R5
  gear_gates_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && $past(hw_trig_en && !src_sel)) |-> $past(gear_full));

  // R7
  ext_needs_high_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && $past(hw_trig_en && src_sel)) |-> $past(ext_trig_pin, 3));

  // R9
  single_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!conv_start && !sw_start_rd));
endmodule

bind adc_start_select adc_start_select_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hw_trig_en   (hw_trig_en),
  .src_sel      (src_sel),
  .gear_full    (gear_full),
  .ext_trig_pin (ext_trig_pin),
  .conv_start   (conv_start),
  .sw_start_rd  (sw_start_rd)
);

// File: tb/test_adc_start_select.sv
module test_adc_start_select;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_trig_en = 1'b0, src_sel = 1'b0, gear_full = 1'b1;
  logic sw_start_wr = 1'b0, sw_start_wdata = 1'b0, ext_trig_pin = 1'b0;
  logic conv_start, sw_start_rd;
  int   n_chk = 0, n_err = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  adc_start_select i_adc_start_select (
    .clk(clk), .rst_n(rst_n), .hw_trig_en(hw_trig_en), .src_sel(src_sel),
    .gear_full(gear_full), .sw_start_wr(sw_start_wr),
    .sw_start_wdata(sw_start_wdata), .ext_trig_pin(ext_trig_pin),
    .conv_start(conv_start), .sw_start_rd(sw_start_rd)
  );

  // {hw, src, wr, wdata, expected readback, expected pulse}
  localparam logic [5:0] VEC [14] = '{
    6'b0000_00, 6'b0011_10, 6'b0000_01, 6'b0000_00,
    6'b0011_10, 6'b0011_01, 6'b0011_10, 6'b0000_01,
    6'b0010_00, 6'b0000_00, 6'b1111_00, 6'b1111_00,
    6'b1100_00, 6'b0100_00
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // run n cycles, count pulses, remember cycle index of first two
  task automatic run_count(input int n, output int cnt, output int first, output int second);
    cnt = 0; first = -1; second = -1;
    for (int i = 1; i <= n; i++) begin
      step();
      if (conv_start) begin
        cnt++;
        if (cnt == 1) first = i;
        if (cnt == 2) second = i;
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int c, f, s;
    repeat (3) @(negedge clk);
    // R10 during reset
    chk("R10", "conv_start in reset", conv_start, 0);
    chk("R10", "sw_start_rd in reset", sw_start_rd, 0);
    rst_n = 1'b1;
    step();
    chk("R10", "conv_start after reset", conv_start, 0);
    chk("R10", "sw_start_rd after reset", sw_start_rd, 0);

    // table walk: software bit behaviour
    for (int r = 0; r < 14; r++) begin
      string req;
      {hw_trig_en, src_sel, sw_start_wr, sw_start_wdata} = VEC[r][5:2];
      req = (r == 5) ? "R2" : ((r == 10 || r == 11) ? "R3" : "R1");
      step();
      chk(req, $sformatf("row %0d readback", r), sw_start_rd, VEC[r][1]);
      chk(req, $sformatf("row %0d pulse", r), conv_start, VEC[r][0]);
    end
    sw_start_wr = 1'b0; sw_start_wdata = 1'b0;

    // R4: periodic mode, first pulse at edge 257, next at 513
    gear_full = 1'b1; hw_trig_en = 1'b1; src_sel = 1'b0;
    run_count(530, c, f, s);
    chk("R4", "periodic pulse count", c, 2);
    chk("R4", "first periodic edge", f, 257);
    chk("R4", "second periodic edge", s, 513);

    // R5: gear low, no pulses
    gear_full = 1'b0;
    run_count(600, c, f, s);
    chk("R5", "pulses with low gear", c, 0);

    // R4: restart after mode change
    gear_full = 1'b1; src_sel = 1'b1;
    run_count(40, c, f, s);
    chk("R7", "ext mode steady low", c, 0);
    src_sel = 1'b0;
    run_count(300, c, f, s);
    chk("R4", "restart first edge", f, 257);
    gear_full = 1'b0;

    // R6: external rising edge, pulse after third edge
    src_sel = 1'b1;
    run_count(6, c, f, s);
    ext_trig_pin = 1'b1;
    run_count(10, c, f, s);
    chk("R6", "ext pulse count", c, 1);
    chk("R6", "ext pulse edge", f, 3);
    // R7: falling edge
    ext_trig_pin = 1'b0;
    run_count(10, c, f, s);
    chk("R7", "falling edge pulses", c, 0);

    // R8: software mode ignores pin
    hw_trig_en = 1'b0;
    run_count(3, c, f, s);
    ext_trig_pin = 1'b1;
    run_count(10, c, f, s);
    chk("R8", "pin edge in soft mode", c, 0);
    gear_full = 1'b1;
    run_count(600, c, f, s);
    chk("R8", "no tick in soft mode", c, 0);

    // R7: enter ext mode with pin already high
    hw_trig_en = 1'b1; src_sel = 1'b1;
    run_count(10, c, f, s);
    chk("R7", "steady high on entry", c, 0);

    // R9: one-cycle pulse width on a software start
    hw_trig_en = 1'b0; src_sel = 1'b0;
    step();
    sw_start_wr = 1'b1; sw_start_wdata = 1'b1;
    step();
    sw_start_wr = 1'b0;
    step();
    chk("R9", "pulse high", conv_start, 1);
    step();
    chk("R9", "pulse low next cycle", conv_start, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule